// File: doc/BRIEF.md
# Lockstep Compare and Retry Controller

This block sits beside two identical copies of a processor's fetch/decode and execute pipelines. Each cycle it looks at the result that each copy wants to retire. When both copies present the same result, it allows the commit and can store that result as the architected checkpoint. When the copies disagree, or only one of them presents a result, it blocks the commit. It then asks for the instruction to be run again from the checkpoint.

A retried instruction gets one attempt. If the retry reports failure, or the copies disagree again, the controller stops the CPU. It then offers the checkpoint to a spare processor through a request/acknowledge handshake.

A saturating error counter tracks every detected disagreement. It is compared with a programmable threshold. Once the count reaches the threshold, the fault is treated as permanent, and the next disagreement skips the retry and goes straight to the stop.

Top module: `lockstep_retry_ctrl`

## Requirements
- R1: `commitEn` is high in the same cycle that both valid strobes are high with equal data, provided the controller is running or retrying. It is low in the stopped and handed-over states.
- R2: `ckptData` takes the retiring result one cycle after a commit with `ckptWe` high. It keeps its value on any cycle without such a commit, including mismatches, single-valid cycles and commits with `ckptWe` low. Its reset value is 0.
- R3: A mismatch while running is a cycle with at least one valid strobe high and not both high with equal data. When such a mismatch leaves the count below the threshold, `commitEn` is low that cycle and `retryReq` rises on the next cycle. `retryReq` then stays high until the retry outcome is known.
- R4: While `retryReq` is high, a matching result with `retryFail` low commits. `retryReq` is low on the following cycle.
- R5: While `retryReq` is high, either a second mismatch or `retryFail` raises `cpuStop` and `xferReq` on the next cycle. `retryFail` has priority over a matching result in the same cycle, and that result does not commit.
- R6: `cpuStop` and `xferReq` stay high until a cycle with `xferAck` high. After that cycle both are low, and no commit occurs until reset.
- R7: `errCount` increases by one for every mismatch seen while running or retrying, saturates at its maximum value, and is cleared only by reset.
- R8: `permFault` is high exactly when `errThresh` is nonzero and `errCount >= errThresh`. A mismatch while running that brings the count to the threshold raises `cpuStop` on the next cycle with no retry.
- R9: During and directly after reset, `commitEn`, `retryReq`, `cpuStop`, `xferReq`, `permFault`, `errCount` and `ckptData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValidA | input | 1 | Pipeline copy A has a retiring result |
| resDataA | input | DATA_W | Result of copy A |
| resValidB | input | 1 | Pipeline copy B has a retiring result |
| resDataB | input | DATA_W | Result of copy B |
| ckptWe | input | 1 | Retiring result updates architected state |
| retryFail | input | 1 | Pipeline reports that the retry could not complete |
| xferAck | input | 1 | Spare processor has taken the checkpoint |
| errThresh | input | CNT_W | Permanent-fault threshold, 0 disables |
| commitEn | output | 1 | Retiring result may commit |
| retryReq | output | 1 | Restore checkpoint and re-run the instruction |
| cpuStop | output | 1 | CPU halted after unrecoverable error |
| xferReq | output | 1 | Request to hand the checkpoint to the spare |
| ckptData | output | DATA_W | Checkpointed architected state |
| errCount | output | CNT_W | Saturating mismatch count |
| permFault | output | 1 | Error rate classified as permanent |

## Verification
Two outcomes can arrive in the same retry cycle: a matching retried result, which would commit, and a `retryFail` report, which would stop the CPU. The bench raises a mismatch to enter retry, then drives equal results on both buses with `ckptWe` and `retryFail` high together. It judges the outcome by `commitEn` being low in that cycle, `cpuStop` rising on the next one, and `ckptData` still holding its old value. A second pairing is a mismatch while running that both counts the error and reaches the threshold. The bench expects the stop on the next cycle with `retryReq` never raised.

// File: rtl/lockstep_retry_pkg.sv
package lockstep_retry_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_RETRY = 2'd1,
    ST_STOP  = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_e;

  typedef struct packed {
    logic ckptWr;
    logic cntInc;
  } dpStrobe_t;
endpackage

// File: rtl/lockstep_retry_dp.sv
module lockstep_retry_dp
  import lockstep_retry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValidA,
  input  logic [DATA_W-1:0] resDataA,
  input  logic              resValidB,
  input  logic [DATA_W-1:0] resDataB,
  input  logic [CNT_W-1:0]  errThresh,
  input  dpStrobe_t         strobe,
  output logic              isMatch,
  output logic              isMismatch,
  output logic              reachThresh,
  output logic [DATA_W-1:0] ckptData,
  output logic [CNT_W-1:0]  errCount,
  output logic              permFault
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              bothValid;
  logic              dataEq;
  logic [CNT_W:0]    cntPlus;
  logic              threshOn;
  logic [DATA_W-1:0] ckptQ;
  logic [CNT_W-1:0]  cntQ;

  assign bothValid   = resValidA & resValidB;
  assign dataEq      = (resDataA == resDataB);
  assign isMatch     = bothValid & dataEq;
  assign isMismatch  = (resValidA | resValidB) & ~isMatch;
  assign threshOn    = (errThresh != '0);
  assign cntPlus     = {1'b0, cntQ} + (CNT_W+1)'(1);
  assign reachThresh = threshOn & (cntPlus >= {1'b0, errThresh});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckptQ <= '0;
    end else if (strobe.ckptWr) begin
      ckptQ <= resDataA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.cntInc && (cntQ != CNT_MAX)) begin
      cntQ <= cntPlus[CNT_W-1:0];
    end
  end

  assign ckptData  = ckptQ;
  assign errCount  = cntQ;
  assign permFault = threshOn & (cntQ >= errThresh);
endmodule

// File: rtl/lockstep_retry_fsm.sv
module lockstep_retry_fsm
  import lockstep_retry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      isMatch,
  input  logic      isMismatch,
  input  logic      reachThresh,
  input  logic      ckptWe,
  input  logic      retryFail,
  input  logic      xferAck,
  output dpStrobe_t strobe,
  output logic      commitEn,
  output logic      retryReq,
  output logic      cpuStop,
  output logic      xferReq
);
  ctrlState_e state;
  ctrlState_e stateNext;
  logic       commitNow;
  logic       countNow;

  always_comb begin
    stateNext = state;
    commitNow = 1'b0;
    countNow  = 1'b0;
    case (state)
      ST_RUN: begin
        commitNow = isMatch;
        if (isMismatch) begin
          countNow  = 1'b1;
          stateNext = reachThresh ? ST_STOP : ST_RETRY;
        end
      end
      ST_RETRY: begin
        if (retryFail) begin
          countNow  = isMismatch;
          stateNext = ST_STOP;
        end else if (isMatch) begin
          commitNow = 1'b1;
          stateNext = ST_RUN;
        end else if (isMismatch) begin
          countNow  = 1'b1;
          stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (xferAck) stateNext = ST_DONE;
      end
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign strobe.ckptWr = commitNow & ckptWe;
  assign strobe.cntInc = countNow;
  assign commitEn      = commitNow;
  assign retryReq      = (state == ST_RETRY);
  assign cpuStop       = (state == ST_STOP);
  assign xferReq       = (state == ST_STOP);
endmodule

// File: rtl/lockstep_retry_ctrl.sv
module lockstep_retry_ctrl
  import lockstep_retry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValidA,
  input  logic [DATA_W-1:0] resDataA,
  input  logic              resValidB,
  input  logic [DATA_W-1:0] resDataB,
  input  logic              ckptWe,
  input  logic              retryFail,
  input  logic              xferAck,
  input  logic [CNT_W-1:0]  errThresh,
  output logic              commitEn,
  output logic              retryReq,
  output logic              cpuStop,
  output logic              xferReq,
  output logic [DATA_W-1:0] ckptData,
  output logic [CNT_W-1:0]  errCount,
  output logic              permFault
);
  dpStrobe_t strobe;
  logic      isMatch;
  logic      isMismatch;
  logic      reachThresh;

  lockstep_retry_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN),
    .resValidA(resValidA), .resDataA(resDataA),
    .resValidB(resValidB), .resDataB(resDataB),
    .errThresh(errThresh), .strobe(strobe),
    .isMatch(isMatch), .isMismatch(isMismatch), .reachThresh(reachThresh),
    .ckptData(ckptData), .errCount(errCount), .permFault(permFault)
  );

  lockstep_retry_fsm uFsm (
    .clk(clk), .rstN(rstN),
    .isMatch(isMatch), .isMismatch(isMismatch), .reachThresh(reachThresh),
    .ckptWe(ckptWe), .retryFail(retryFail), .xferAck(xferAck),
    .strobe(strobe),
    .commitEn(commitEn), .retryReq(retryReq),
    .cpuStop(cpuStop), .xferReq(xferReq)
  );
endmodule

// File: rtl/lockstep_retry_chk.sv
module lockstep_retry_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              resValidA,
  input logic              resValidB,
  input logic              retryFail,
  input logic              xferAck,
  input logic              commitEn,
  input logic              retryReq,
  input logic              cpuStop,
  input logic              xferReq,
  input logic [DATA_W-1:0] ckptData,
  input logic [CNT_W-1:0]  errCount
);
  a_r1_no_commit_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    cpuStop |-> !commitEn);

  a_r2_ckpt_holds: assert property (@(posedge clk) disable iff (!rstN)
    !commitEn |=> $stable(ckptData));

  a_r3_retry_excludes_stop: assert property (@(posedge clk) disable iff (!rstN)
    !(retryReq && cpuStop));

  a_r5_fail_stops: assert property (@(posedge clk) disable iff (!rstN)
    (retryReq && retryFail) |=> cpuStop);

  a_r5_single_valid_in_retry_stops: assert property (@(posedge clk) disable iff (!rstN)
    (retryReq && (resValidA != resValidB)) |=> cpuStop);

  a_r6_stop_held: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStop && !xferAck) |=> (cpuStop && xferReq));

  a_r6_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStop && xferAck) |=> (!cpuStop && !xferReq && !commitEn));

  a_r7_count_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) || 1'b1 |=> (errCount >= $past(errCount)));
endmodule

bind lockstep_retry_ctrl lockstep_retry_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .resValidA(resValidA), .resValidB(resValidB),
  .retryFail(retryFail), .xferAck(xferAck),
  .commitEn(commitEn), .retryReq(retryReq),
  .cpuStop(cpuStop), .xferReq(xferReq),
  .ckptData(ckptData), .errCount(errCount)
);

// File: tb/lockstep_retry_ctrl_test.sv
`timescale 1ns/1ps
module lockstep_retry_ctrl_test;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              resValidA, resValidB, ckptWe, retryFail, xferAck;
  logic [DATA_W-1:0] resDataA, resDataB;
  logic [CNT_W-1:0]  errThresh;
  logic              commitEn, retryReq, cpuStop, xferReq, permFault;
  logic [DATA_W-1:0] ckptData;
  logic [CNT_W-1:0]  errCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lockstep_retry_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN),
    .resValidA(resValidA), .resDataA(resDataA),
    .resValidB(resValidB), .resDataB(resDataB),
    .ckptWe(ckptWe), .retryFail(retryFail), .xferAck(xferAck),
    .errThresh(errThresh),
    .commitEn(commitEn), .retryReq(retryReq), .cpuStop(cpuStop),
    .xferReq(xferReq), .ckptData(ckptData), .errCount(errCount),
    .permFault(permFault)
  );

  typedef struct packed {
    logic       vA;
    logic [7:0] dA;
    logic       vB;
    logic [7:0] dB;
    logic       we;
    logic       fail;
    logic       ack;
    logic       eCommit;
    logic       eRetry;
    logic       eStop;
    logic       ePerm;
    logic [7:0] eCnt;
    logic [7:0] eCkpt;
  } vec_t;

  localparam int NVEC = 12;
  // Threshold 3. Registered expectations are the values before the vector's clock edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,8'd5,1'b1,8'd5,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,8'd0,8'd0},
    '{1'b1,8'd7,1'b0,8'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'd0,8'd5},
    '{1'b0,8'd0,1'b0,8'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,8'd1,8'd5},
    '{1'b1,8'd7,1'b1,8'd7,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,8'd1,8'd5},
    '{1'b1,8'd1,1'b1,8'd2,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'd1,8'd7},
    '{1'b1,8'd1,1'b1,8'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,8'd2,8'd7},
    '{1'b0,8'd0,1'b0,8'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'd2,8'd7},
    '{1'b1,8'd3,1'b1,8'd4,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,8'd2,8'd7},
    '{1'b0,8'd0,1'b0,8'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,8'd3,8'd7},
    '{1'b1,8'd9,1'b1,8'd9,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,8'd3,8'd7},
    '{1'b0,8'd0,1'b0,8'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b1,8'd3,8'd7},
    '{1'b1,8'd9,1'b1,8'd9,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,8'd3,8'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic vA, input logic [31:0] dA, input logic vB,
                       input logic [31:0] dB, input logic we, input logic fail,
                       input logic ack);
    resValidA = vA; resDataA = dA; resValidB = vB; resDataB = dB;
    ckptWe = we; retryFail = fail; xferAck = ack;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset(input logic [CNT_W-1:0] th);
    @(negedge clk);
    rstN = 1'b0; errThresh = th;
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; errThresh = '0;
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 commitEn", 32'(commitEn), 0);
    chk("R9 retryReq", 32'(retryReq), 0);
    chk("R9 cpuStop", 32'(cpuStop), 0);
    chk("R9 xferReq", 32'(xferReq), 0);
    chk("R9 errCount", 32'(errCount), 0);
    chk("R9 ckptData", ckptData, 0);
    chk("R9 permFault", 32'(permFault), 0);

    // Vector table walk
    doReset(8'd3);
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].vA, 32'(VECS[i].dA), VECS[i].vB, 32'(VECS[i].dB),
            VECS[i].we, VECS[i].fail, VECS[i].ack);
      #1;
      chk("R1 commitEn", 32'(commitEn), 32'(VECS[i].eCommit));
      chk("R3 retryReq", 32'(retryReq), 32'(VECS[i].eRetry));
      chk("R5 cpuStop", 32'(cpuStop), 32'(VECS[i].eStop));
      chk("R6 xferReq", 32'(xferReq), 32'(VECS[i].eStop));
      chk("R8 permFault", 32'(permFault), 32'(VECS[i].ePerm));
      chk("R7 errCount", 32'(errCount), 32'(VECS[i].eCnt));
      chk("R2 ckptData", ckptData, 32'(VECS[i].eCkpt));
      step();
    end

    // retryFail and matching retried result in the same cycle
    doReset(8'd0);
    drive(1'b1, 32'd11, 1'b1, 32'd12, 1'b1, 1'b0, 1'b0);
    step();
    drive(1'b1, 32'd6, 1'b1, 32'd6, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R4 retryReq during retry", 32'(retryReq), 1);
    chk("R5 fail beats match commit", 32'(commitEn), 0);
    step();
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R5 stop after fail", 32'(cpuStop), 1);
    chk("R5 xferReq after fail", 32'(xferReq), 1);
    chk("R2 ckpt not written", ckptData, 0);
    chk("R7 fail alone not counted", 32'(errCount), 1);
    step();
    #1;
    chk("R6 stop held without ack", 32'(cpuStop), 1);
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    step();
    drive(1'b1, 32'd4, 1'b1, 32'd4, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R6 stop released", 32'(cpuStop), 0);
    chk("R6 no commit after handover", 32'(commitEn), 0);

    // Retry success path then reset clears counter
    doReset(8'd0);
    drive(1'b0, 0, 1'b1, 32'd8, 1'b1, 1'b0, 1'b0);
    step();
    drive(1'b1, 32'd8, 1'b1, 32'd8, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R4 retried match commits", 32'(commitEn), 1);
    step();
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R4 retryReq drops", 32'(retryReq), 0);
    chk("R2 ckpt from retry", ckptData, 8);
    chk("R7 counted once", 32'(errCount), 1);

    // Second mismatch in retry
    doReset(8'd0);
    chk("R7 cleared by reset", 32'(errCount), 0);
    drive(1'b1, 32'd1, 1'b1, 32'd2, 1'b1, 1'b0, 1'b0);
    step();
    drive(1'b1, 32'd1, 1'b1, 32'd3, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R5 second mismatch no commit", 32'(commitEn), 0);
    step();
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R5 second mismatch stops", 32'(cpuStop), 1);
    chk("R7 two mismatches", 32'(errCount), 2);

    // Saturation with threshold disabled
    doReset(8'd0);
    for (int k = 0; k < 260; k++) begin
      drive(1'b1, 32'd1, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);
      step();
      drive(1'b1, 32'd1, 1'b1, 32'd1, 1'b0, 1'b0, 1'b0);
      step();
    end
    drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R7 saturates", 32'(errCount), 255);
    chk("R8 threshold zero disables", 32'(permFault), 0);
    chk("R3 back to run", 32'(retryReq), 0);
    errThresh = 8'd255;
    #1;
    chk("R8 count at threshold", 32'(permFault), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule